// File: doc/BRIEF.md
# Flash Charge and Fire Controller

This block sequences an electronic flash. When asked to charge, it turns on the high-voltage charger and watches a comparator input. That input reports whether the divided-down capacitor voltage has reached its set level. The controller shuts the charger off as soon as the level is confirmed, then reports that the flash is ready.

A fire command in the ready state starts emission. The controller raises an arm output for one cycle and then issues a trigger pulse of programmable length, with arm held high throughout. A stop command ends any activity at once. After emission or a stop, the controller goes back to idle. If the charge request is still held, it starts charging again.

The comparator input is asynchronous. It passes through a two-flop synchroniser, and a threshold counts only after several consecutive high samples. If the level is not confirmed within a programmable number of cycles, charging is abandoned and a fault flag is set. The flag stays set until reset.

Top module: `flash_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, chargeEn, ready, arm, trigger and fault are all low.
- R2: From idle with chargeReq high and no fault, chargeEn goes high one clock later and stays high only while charging.
- R3: atLevel is confirmed only after two synchroniser flops plus CONFIRM_N (default 4) consecutive high samples. ready therefore rises CONFIRM_N+3 clocks after atLevel rises, in the same cycle that chargeEn falls.
- R4: A high level on atLevel shorter than CONFIRM_N synchronised samples is not taken as the threshold, and charging continues.
- R5: fireCmd in the ready state drops ready and raises arm alone for one cycle. Then trigger is high for pulseLen cycles (a pulseLen of 0 counts as 1), with arm high during the whole pulse. trigger is never high without arm.
- R6: fireCmd outside the ready state is ignored: neither arm nor trigger rises.
- R7: stopCmd in any state sends the controller to idle on the next clock, with chargeEn, ready, arm and trigger all low.
- R8: After a trigger pulse ends, or after a stop, the controller is idle for one cycle. If chargeReq is still high, chargeEn rises on the following clock.
- R9: If the threshold is not confirmed, chargeEn stays high for exactly timeoutLimit+1 cycles. Then fault rises and stays high until reset, and no charging starts while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chargeReq | input | 1 | Level request to charge the flash capacitor |
| atLevel | input | 1 | Asynchronous comparator: capacitor voltage at or above the set level |
| fireCmd | input | 1 | Fire command, acted on only when ready |
| stopCmd | input | 1 | Abort charging or emission |
| timeoutLimit | input | TW | Charge time budget in clocks (window is timeoutLimit+1) |
| pulseLen | input | PW | Trigger pulse length in clocks (0 treated as 1) |
| chargeEn | output | 1 | High-voltage charger enable |
| ready | output | 1 | Capacitor charged, waiting for fire |
| arm | output | 1 | Emission armed (held through the trigger pulse) |
| trigger | output | 1 | Trigger pulse |
| fault | output | 1 | Sticky charge timeout flag |

## Verification
The properties assume that fireCmd and stopCmd are synchronous to clk. They also assume that timeoutLimit and pulseLen stay constant while a charge or an emission is in progress. The only input allowed to change at any time is atLevel. The stimulus drives every input on the falling edge. It changes pulseLen and timeoutLimit only while the controller is idle, charging with a limit far from expiry, or ready. The randomised part draws pulse lengths, timeout limits and charge delays that stay inside those bounds.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHARGE,
    S_READY,
    S_ARM,
    S_TRIG
  } state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic runTimer;
    logic runPulse;
  } ctrl_t;

  // datapath -> control status
  typedef struct packed {
    logic levelOk;
    logic timeoutHit;
    logic pulseDone;
  } stat_t;

endpackage

// File: rtl/flash_dp.sv
module flash_dp
  import flash_pkg::*;
#(
  parameter int CONFIRM_N = 4,
  parameter int SYNC_N    = 2,
  parameter int TW        = 16,
  parameter int PW        = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          atLevel,
  input  logic [TW-1:0] timeoutLimit,
  input  logic [PW-1:0] pulseLen,
  input  ctrl_t         ctrl,
  output stat_t         stat
);
  localparam int CW = $clog2(CONFIRM_N + 1);
  localparam logic [CW-1:0] CONF_MAX = CW'(CONFIRM_N);

  logic [SYNC_N-1:0] syncQ;
  logic [CW-1:0]     confirmCnt;
  logic [TW-1:0]     timer;
  logic [PW-1:0]     pulseCnt;
  logic [PW-1:0]     pulseLast;

  // synchroniser chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[g] <= 1'b0;
        else if (g == 0) syncQ[g] <= atLevel;
        else             syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  // consecutive-sample confirmation, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        confirmCnt <= '0;
    else if (!syncQ[SYNC_N-1])        confirmCnt <= '0;
    else if (confirmCnt != CONF_MAX)  confirmCnt <= confirmCnt + 1'b1;
  end

  // charge-time budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (ctrl.runTimer) timer <= timer + 1'b1;
    else                    timer <= '0;
  end

  // trigger pulse length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (ctrl.runPulse) pulseCnt <= pulseCnt + 1'b1;
    else                    pulseCnt <= '0;
  end

  assign pulseLast       = (pulseLen == '0) ? '0 : pulseLen - 1'b1;
  assign stat.levelOk    = (confirmCnt == CONF_MAX);
  assign stat.timeoutHit = ctrl.runTimer && (timer == timeoutLimit);
  assign stat.pulseDone  = ctrl.runPulse && (pulseCnt == pulseLast);

endmodule

// File: rtl/flash_fsm.sv
module flash_fsm
  import flash_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  chargeReq,
  input  logic  fireCmd,
  input  logic  stopCmd,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  chargeEn,
  output logic  ready,
  output logic  arm,
  output logic  trigger,
  output logic  fault
);
  state_t state, nextState;
  logic   faultQ, setFault;

  always_comb begin
    nextState = state;
    setFault  = 1'b0;
    if (stopCmd) begin
      nextState = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:   if (chargeReq && !faultQ) nextState = S_CHARGE;
        S_CHARGE: begin
          if (stat.levelOk)         nextState = S_READY;
          else if (stat.timeoutHit) begin
            nextState = S_IDLE;
            setFault  = 1'b1;
          end
          else if (!chargeReq)      nextState = S_IDLE;
        end
        S_READY:  if (fireCmd)        nextState = S_ARM;
        S_ARM:    nextState = S_TRIG;
        S_TRIG:   if (stat.pulseDone) nextState = S_IDLE;
        default:  nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      faultQ <= 1'b0;
    end else begin
      state  <= nextState;
      faultQ <= faultQ | setFault;
    end
  end

  assign ctrl.runTimer = (state == S_CHARGE);
  assign ctrl.runPulse = (state == S_TRIG);

  assign chargeEn = (state == S_CHARGE);
  assign ready    = (state == S_READY);
  assign arm      = (state == S_ARM) || (state == S_TRIG);
  assign trigger  = (state == S_TRIG);
  assign fault    = faultQ;

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int CONFIRM_N = 4,
  parameter int TW        = 16,
  parameter int PW        = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chargeReq,
  input  logic          atLevel,
  input  logic          fireCmd,
  input  logic          stopCmd,
  input  logic [TW-1:0] timeoutLimit,
  input  logic [PW-1:0] pulseLen,
  output logic          chargeEn,
  output logic          ready,
  output logic          arm,
  output logic          trigger,
  output logic          fault
);
  ctrl_t ctrl;
  stat_t stat;

  flash_dp #(
    .CONFIRM_N(CONFIRM_N),
    .SYNC_N   (2),
    .TW       (TW),
    .PW       (PW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .atLevel     (atLevel),
    .timeoutLimit(timeoutLimit),
    .pulseLen    (pulseLen),
    .ctrl        (ctrl),
    .stat        (stat)
  );

  flash_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .chargeReq(chargeReq),
    .fireCmd  (fireCmd),
    .stopCmd  (stopCmd),
    .stat     (stat),
    .ctrl     (ctrl),
    .chargeEn (chargeEn),
    .ready    (ready),
    .arm      (arm),
    .trigger  (trigger),
    .fault    (fault)
  );

endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic fireCmd,
  input logic stopCmd,
  input logic chargeEn,
  input logic ready,
  input logic arm,
  input logic trigger,
  input logic fault
);

  p_excl_outs_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chargeEn, ready, arm}));

  p_ready_after_charge_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(chargeEn));

  p_trig_needs_arm_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> arm);

  p_arm_before_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigger) |-> ($past(arm) && !$past(trigger)));

  p_arm_only_from_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arm) |-> ($past(ready) && $past(fireCmd)));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (!chargeEn && !ready && !arm && !trigger));

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  p_fault_no_charge_r9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !chargeEn);

endmodule

bind flash_ctrl flash_ctrl_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .fireCmd (fireCmd),
  .stopCmd (stopCmd),
  .chargeEn(chargeEn),
  .ready   (ready),
  .arm     (arm),
  .trigger (trigger),
  .fault   (fault)
);

// File: tb/sim_flash_ctrl.sv
`timescale 1ns/1ps
module sim_flash_ctrl;
  localparam int CONFIRM_N = 4;
  localparam int TW = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chargeReq = 1'b0, atLevel = 1'b0, fireCmd = 1'b0, stopCmd = 1'b0;
  logic [TW-1:0] timeoutLimit = '0;
  logic [PW-1:0] pulseLen = '0;
  logic chargeEn, ready, arm, trigger, fault;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_ctrl #(.CONFIRM_N(CONFIRM_N), .TW(TW), .PW(PW)) u0 (
    .clk(clk), .rstN(rstN), .chargeReq(chargeReq), .atLevel(atLevel),
    .fireCmd(fireCmd), .stopCmd(stopCmd), .timeoutLimit(timeoutLimit),
    .pulseLen(pulseLen), .chargeEn(chargeEn), .ready(ready), .arm(arm),
    .trigger(trigger), .fault(fault)
  );

  function automatic int expTrigLen(input int pl);
    return (pl == 0) ? 1 : pl;
  endfunction

  function automatic int expReadyLat();
    return CONFIRM_N + 3;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; chargeReq = 0; atLevel = 0; fireCmd = 0; stopCmd = 0;
    tick(3);
    check("R1 outputs in reset", {chargeEn, ready, arm, trigger, fault}, 0);
    rstN = 1'b1;
    tick(1);
    check("R1 outputs after reset", {chargeEn, ready, arm, trigger, fault}, 0);
  endtask

  // raise atLevel while charging, return cycles until ready
  task automatic waitReady(output int lat);
    atLevel = 1'b1;
    lat = 0;
    while (!ready && lat < 50) begin
      tick(1);
      lat++;
    end
    atLevel = 1'b0;
  endtask

  // fire from ready, return observed trigger width
  task automatic fireAndMeasure(output int w);
    fireCmd = 1'b1;
    tick(1);
    fireCmd = 1'b0;
    check("R5 arm alone after fire", {arm, trigger, ready}, 3'b100);
    w = 0;
    tick(1);
    while (trigger && w < 300) begin
      if (!arm) check("R5 arm during trigger", arm, 1);
      w++;
      tick(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, w;
    void'($urandom(32'd1234));
    timeoutLimit = 16'd1000;
    doReset();

    // R2 charge start
    chargeReq = 1'b1;
    tick(1);
    check("R2 chargeEn after request", chargeEn, 1);
    check("R2 not ready while charging", ready, 0);

    // R6 fire while charging ignored
    fireCmd = 1'b1; tick(1); fireCmd = 1'b0; tick(1);
    check("R6 fire while charging", {arm, trigger, chargeEn}, 3'b001);

    // R4 short level glitch
    atLevel = 1'b1; tick(CONFIRM_N - 1); atLevel = 1'b0; tick(8);
    check("R4 glitch not confirmed", {ready, chargeEn}, 2'b01);

    // R3 latency
    waitReady(lat);
    check("R3 ready latency", lat, expReadyLat());
    check("R3 charger off at ready", chargeEn, 0);

    // R5 trigger width and R8 recharge
    pulseLen = 8'd3;
    fireAndMeasure(w);
    check("R5 trigger width 3", w, expTrigLen(3));
    check("R8 idle after emission", {chargeEn, arm}, 0);
    tick(1);
    check("R8 recharge after emission", chargeEn, 1);

    // R7 stop during trigger
    tick(4);
    waitReady(lat);
    check("R3 ready latency second", lat, expReadyLat());
    pulseLen = 8'd10;
    fireCmd = 1'b1; tick(1); fireCmd = 1'b0;
    tick(3);
    check("R5 trigger running", trigger, 1);
    stopCmd = 1'b1; tick(1);
    check("R7 stop ends trigger", {arm, trigger, ready, chargeEn}, 0);
    stopCmd = 1'b0; tick(1);
    check("R8 recharge after stop", chargeEn, 1);

    // R7 stop during charge
    stopCmd = 1'b1; tick(1);
    check("R7 stop ends charge", chargeEn, 0);
    stopCmd = 1'b0; tick(1);
    check("R8 recharge after charge stop", chargeEn, 1);

    // randomised emission loop
    for (int i = 0; i < 10; i++) begin
      int pl;
      pl = $urandom_range(0, 6);
      pulseLen = PW'(pl);
      tick($urandom_range(3, 8));
      check("R2 charging before level", chargeEn, 1);
      waitReady(lat);
      check("R3 ready latency random", lat, expReadyLat());
      fireAndMeasure(w);
      check("R5 trigger width random", w, expTrigLen(pl));
      tick(1);
      check("R8 recharge random", chargeEn, 1);
    end

    // R9 timeout, directed then random limits
    for (int k = 0; k < 3; k++) begin
      int lim, n;
      lim = (k == 0) ? 5 : ((k == 1) ? 0 : $urandom_range(1, 40));
      doReset();
      timeoutLimit = TW'(lim);
      chargeReq = 1'b1;
      tick(1);
      n = 0;
      while (chargeEn && n < 200) begin
        n++;
        tick(1);
      end
      check("R9 charge window", n, lim + 1);
      check("R9 fault set", fault, 1);
      tick(5);
      check("R9 no charge under fault", {chargeEn, fault}, 2'b01);
      fireCmd = 1'b1; tick(1); fireCmd = 1'b0; tick(1);
      check("R6 fire under fault ignored", {arm, trigger}, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule